// File: doc/BRIEF.md
# Open-Switch Fault Diagnosis Sequencer

This block decides whether one leg of a three-phase, three-level hybrid inverter has lost a switch to an open-circuit failure, and then names the failed device. Each leg has six devices. Four are slow outer and clamp switches, and two are fast inner switches. Upstream, a current-vector tracker reduces the phase currents to a trace in the stationary frame. Every time it has a new result it delivers three things: the trace radius, the magnitude of the offset of the trace centre from the origin, and which of six 60-degree sectors the centre angle falls in. Sector k spans k*60 degrees plus or minus 30 degrees, so sector 0 lies on the positive d axis and sector 3 on the negative d axis.

A healthy inverter draws a circle of constant radius. When the radius departs from its programmed nominal value on enough consecutive samples, the sequencer raises the fault flag. It reads the faulty leg and the side of the leg from the centre sector. A small centre offset marks a clamp-switch fault, which the pattern alone identifies. A large offset means the outer slow switch and the fast switch on that side cannot be told apart. The sequencer then asks the gate generator for a brief zero-state injection and watches the phase current for a spike. If a spike appears, the slow outer switch is open, because the fast device still carries current. If no spike appears, the fast device is open.

The states are: MON (watch samples), CLS (classify the latched sector and offset), REQ (injection requested, waiting for the grant), WIN (injection window, watching the current) and DONE (result held). The transitions are:
- MON to CLS on a confirmed fault.
- CLS to DONE for a small offset, or CLS to REQ for a large one.
- REQ to WIN on a grant, or REQ to DONE on a grant timeout.
- WIN to DONE on a spike, or on expiry of the window.
- Any state to MON on clear.

Top module: `swd_seq`

## Requirements
- R1: After reset, or one cycle after `clr` is high in any state, `flt`=0, `sw_code`=0, `flt_leg`=0 and `inj_req`=0, and monitoring restarts.
- R2: A sample is deviant when |`rad_in` - `rad_nom`| > `rad_tol`. A difference equal to the tolerance is not deviant. A non-deviant sample resets the run of deviant samples. `flt` rises on the clock edge that takes the CONF_N-th consecutive deviant sample (default 2) with a valid sector, which is well within one fundamental period.
- R3: The sector of the confirming sample selects the leg and the side. `flt_leg` is 1 (leg A) for sectors 0 and 3, 3 (leg C) for sectors 1 and 4, and 2 (leg B) for sectors 2 and 5. Odd sectors mean an upper-side fault (`inj_upper`=1) and even sectors a lower-side fault. Sectors 6 and 7 never confirm a fault.
- R4: If `ctr_mag` < `ctr_thr` at confirmation, the code is 6 (upper clamp switch) for an upper-side sector and 5 (lower clamp switch) for a lower-side sector. In that case `inj_req` never rises.
- R5: If `ctr_mag` >= `ctr_thr`, `inj_req` rises one cycle after `flt`. It stays high through the grant and the injection window.
- R6: Upper side: the current sampled on the grant edge is the base. Any window cycle with |`phase_i` - base| > `spk_thr` gives code 1 (outer slow switch open). A window of WIN_LEN cycles (default 8) without such a cycle gives code 2 (upper fast switch open).
- R7: Lower side: only a negative change counts, base - `phase_i` > `spk_thr`, and it gives code 4 (outer slow switch open). Positive changes are ignored. A window without a spike gives code 3 (lower fast switch open).
- R8: If `inj_ack` does not arrive within ACK_TO cycles of REQ (default 16), `inj_req` drops and the no-spike code is recorded: 2 for the upper side, 3 for the lower side.
- R9: Once the fault is raised, `flt`, `flt_leg` and a non-zero `sw_code` hold until `clr`. Further samples are ignored, and at most one injection request is made per diagnosis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clears the sticky result and restarts monitoring |
| smp_vld | input | 1 | New tracker sample present |
| rad_in | input | W | Trace radius |
| ctr_sect | input | 3 | Sector of the trace-centre angle (0..5 valid) |
| ctr_mag | input | W | Magnitude of the trace-centre offset |
| rad_nom | input | W | Healthy radius setting |
| rad_tol | input | W | Allowed radius deviation |
| ctr_thr | input | W | Offset separating outer-device from clamp faults |
| spk_thr | input | W | Current change that counts as a spike |
| phase_i | input | W | Signed current of the leg under test |
| inj_ack | input | 1 | Gate generator has applied the zero state |
| flt | output | 1 | Sticky inverter fault flag |
| sw_code | output | 3 | Failed switch code (0 = none, 1..6) |
| flt_leg | output | 2 | Faulty leg: 1 = A, 2 = B, 3 = C |
| inj_req | output | 1 | Zero-state injection request |
| inj_upper | output | 1 | Requested zero state belongs to the upper side |

## Verification
The checker assumes that `clr` is a clean synchronous pulse, and that the register inputs stay constant while a diagnosis runs. The bench programs the thresholds once and leaves them alone, and it pulses `clr` for exactly one cycle between scenarios. The checker also assumes that `inj_ack` only matters while a request is open. The bench raises the grant only after it has seen `inj_req` high, except in one deliberate case after a finished diagnosis that shows a late grant cannot start a second request. Sector values 6 and 7 appear only in the scenario that shows they cannot confirm a fault.

// File: rtl/swd_pkg.sv
package swd_pkg;
    typedef enum logic [2:0] {
        ST_MON  = 3'd0,
        ST_CLS  = 3'd1,
        ST_REQ  = 3'd2,
        ST_WIN  = 3'd3,
        ST_DONE = 3'd4
    } swd_state_e;

    // failed-switch codes (decoded by the fault handler downstream)
    localparam logic [2:0] SW_NONE    = 3'd0;
    localparam logic [2:0] SW_UP_SLOW = 3'd1;
    localparam logic [2:0] SW_UP_FAST = 3'd2;
    localparam logic [2:0] SW_LO_FAST = 3'd3;
    localparam logic [2:0] SW_LO_SLOW = 3'd4;
    localparam logic [2:0] SW_MID_LO  = 3'd5;
    localparam logic [2:0] SW_MID_HI  = 3'd6;

    localparam logic [1:0] LEG_NONE = 2'd0;
    localparam logic [1:0] LEG_A    = 2'd1;
    localparam logic [1:0] LEG_B    = 2'd2;
    localparam logic [1:0] LEG_C    = 2'd3;
endpackage

// File: rtl/swd_sector_map.sv
module swd_sector_map
    import swd_pkg::*;
(
    input  logic [2:0] sect,
    output logic       valid,
    output logic [1:0] leg,
    output logic       upper
);
    // R3: sector of centre angle -> leg and side
    always_comb begin
        valid = (sect < 3'd6);
        upper = sect[0];
        case (sect)
            3'd0, 3'd3: leg = LEG_A;
            3'd2, 3'd5: leg = LEG_B;
            3'd1, 3'd4: leg = LEG_C;
            default:    leg = LEG_NONE;
        endcase
    end
endmodule

// File: rtl/swd_dev_mon.sv
module swd_dev_mon #(
    parameter int W      = 16,
    parameter int CONF_N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         arm,
    input  logic         smp_vld,
    input  logic [W-1:0] rad_in,
    input  logic [W-1:0] rad_nom,
    input  logic [W-1:0] rad_tol,
    input  logic         sect_ok,
    output logic         confirm
);
    localparam int CNTW = $clog2(CONF_N + 1);
    localparam logic [CNTW-1:0] NEED = CNTW'(CONF_N - 1);
    localparam logic [CNTW-1:0] CMAX = CNTW'(CONF_N);

    logic [W-1:0]    diff;
    logic            dev;
    logic [CNTW-1:0] run_cnt;

    always_comb begin
        diff = (rad_in >= rad_nom) ? (rad_in - rad_nom) : (rad_nom - rad_in);
        dev  = (diff > rad_tol);
    end

    assign confirm = arm && smp_vld && dev && sect_ok && (run_cnt >= NEED);

    always_ff @(posedge clk) begin
        if (!rst_n || clr || !arm) begin
            run_cnt <= '0;
        end else if (smp_vld) begin
            if (!dev)
                run_cnt <= '0;
            else if (run_cnt != CMAX)
                run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/swd_spike_det.sv
module swd_spike_det #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic         upper,
    input  logic [W-1:0] phase_i,
    input  logic [W-1:0] spk_thr,
    output logic         spike
);
    logic        [W-1:0] base_q;
    logic signed [W:0]   delta;
    logic signed [W:0]   ndelta;
    logic        [W:0]   amag;

    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (cap)
            base_q <= phase_i;
    end

    always_comb begin
        delta  = $signed({phase_i[W-1], phase_i}) - $signed({base_q[W-1], base_q});
        ndelta = -delta;
        amag   = delta[W] ? $unsigned(ndelta) : $unsigned(delta);
        if (upper)
            spike = (amag > {1'b0, spk_thr});
        else
            spike = !ndelta[W] && ($unsigned(ndelta) > {1'b0, spk_thr});
    end
endmodule

// File: rtl/swd_seq.sv
module swd_seq
    import swd_pkg::*;
#(
    parameter int W       = 16,
    parameter int CONF_N  = 2,
    parameter int WIN_LEN = 8,
    parameter int ACK_TO  = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         smp_vld,
    input  logic [W-1:0] rad_in,
    input  logic [2:0]   ctr_sect,
    input  logic [W-1:0] ctr_mag,
    input  logic [W-1:0] rad_nom,
    input  logic [W-1:0] rad_tol,
    input  logic [W-1:0] ctr_thr,
    input  logic [W-1:0] spk_thr,
    input  logic [W-1:0] phase_i,
    input  logic         inj_ack,
    output logic         flt,
    output logic [2:0]   sw_code,
    output logic [1:0]   flt_leg,
    output logic         inj_req,
    output logic         inj_upper
);
    localparam int TMAX = (ACK_TO > WIN_LEN) ? ACK_TO : WIN_LEN;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] ACK_LAST = CW'(ACK_TO - 1);
    localparam logic [CW-1:0] WIN_LAST = CW'(WIN_LEN - 1);

    swd_state_e   st, nxt;
    logic [2:0]   nxt_code;
    logic [2:0]   code_q;
    logic [1:0]   leg_q;
    logic         flt_q, upper_q, outer_q;
    logic [CW-1:0] cnt;

    logic         sect_ok, map_upper, confirm, spike;
    logic [1:0]   map_leg;

    swd_sector_map u_map (
        .sect  (ctr_sect),
        .valid (sect_ok),
        .leg   (map_leg),
        .upper (map_upper)
    );

    swd_dev_mon #(.W(W), .CONF_N(CONF_N)) u_dev (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .arm     (st == ST_MON),
        .smp_vld (smp_vld),
        .rad_in  (rad_in),
        .rad_nom (rad_nom),
        .rad_tol (rad_tol),
        .sect_ok (sect_ok),
        .confirm (confirm)
    );

    swd_spike_det #(.W(W)) u_spk (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     ((st == ST_REQ) && inj_ack),
        .upper   (upper_q),
        .phase_i (phase_i),
        .spk_thr (spk_thr),
        .spike   (spike)
    );

    // next state and decided code
    always_comb begin
        nxt      = st;
        nxt_code = code_q;
        unique case (st)
            ST_MON: begin
                if (confirm) nxt = ST_CLS;
            end
            ST_CLS: begin
                if (outer_q) begin
                    nxt = ST_REQ;
                end else begin
                    nxt      = ST_DONE;
                    nxt_code = upper_q ? SW_MID_HI : SW_MID_LO;
                end
            end
            ST_REQ: begin
                if (inj_ack) begin
                    nxt = ST_WIN;
                end else if (cnt == ACK_LAST) begin
                    nxt      = ST_DONE;
                    nxt_code = upper_q ? SW_UP_FAST : SW_LO_FAST;
                end
            end
            ST_WIN: begin
                if (spike) begin
                    nxt      = ST_DONE;
                    nxt_code = upper_q ? SW_UP_SLOW : SW_LO_SLOW;
                end else if (cnt == WIN_LAST) begin
                    nxt      = ST_DONE;
                    nxt_code = upper_q ? SW_UP_FAST : SW_LO_FAST;
                end
            end
            ST_DONE: begin
                nxt = ST_DONE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            st <= ST_MON;
        else
            st <= nxt;
    end

    // output and bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flt_q   <= 1'b0;
            leg_q   <= LEG_NONE;
            upper_q <= 1'b0;
            outer_q <= 1'b0;
            code_q  <= SW_NONE;
            cnt     <= '0;
        end else begin
            if (st == ST_MON && nxt == ST_CLS) begin
                flt_q   <= 1'b1;
                leg_q   <= map_leg;
                upper_q <= map_upper;
                outer_q <= (ctr_mag >= ctr_thr);
            end
            code_q <= nxt_code;
            if (nxt != st)
                cnt <= '0;
            else if (st == ST_REQ || st == ST_WIN)
                cnt <= cnt + 1'b1;
        end
    end

    assign flt       = flt_q;
    assign sw_code   = code_q;
    assign flt_leg   = leg_q;
    assign inj_req   = (st == ST_REQ) || (st == ST_WIN);
    assign inj_upper = upper_q;
endmodule

// File: rtl/swd_seq_chk.sv
module swd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr,
    input logic       flt,
    input logic [2:0] sw_code,
    input logic [1:0] flt_leg,
    input logic       inj_req
);
    logic prev_req, req_spent;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prev_req  <= 1'b0;
            req_spent <= 1'b0;
        end else begin
            prev_req <= inj_req;
            if (prev_req && !inj_req)
                req_spent <= 1'b1;
        end
    end

    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!flt && sw_code == 3'd0 && flt_leg == 2'd0 && !inj_req));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flt && !clr) |=> flt);

    a_r9_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_code != 3'd0 && !clr) |=> ($stable(sw_code) && $stable(flt_leg)));

    a_r9_single_req: assert property (@(posedge clk) disable iff (!rst_n || clr)
        req_spent |-> !inj_req);

    a_r5_req_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
        inj_req |-> (flt && flt_leg != 2'd0 && sw_code == 3'd0));

    a_r4_clamp_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_code == 3'd5 || sw_code == 3'd6) |-> !inj_req);

    a_r2_code_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_code != 3'd0) |-> (flt && sw_code != 3'd7));
endmodule

bind swd_seq swd_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .flt     (flt),
    .sw_code (sw_code),
    .flt_leg (flt_leg),
    .inj_req (inj_req)
);

// File: tb/swd_seq_bench.sv
module swd_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W       = 16;
    localparam int CONF_N  = 2;
    localparam int WIN_LEN = 8;
    localparam int ACK_TO  = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         smp_vld = 1'b0;
    logic [W-1:0] rad_in = '0;
    logic [2:0]   ctr_sect = '0;
    logic [W-1:0] ctr_mag = '0;
    logic [W-1:0] rad_nom = 16'd1000;
    logic [W-1:0] rad_tol = 16'd50;
    logic [W-1:0] ctr_thr = 16'd100;
    logic [W-1:0] spk_thr = 16'd80;
    logic [W-1:0] phase_i = '0;
    logic         inj_ack = 1'b0;
    logic         flt;
    logic [2:0]   sw_code;
    logic [1:0]   flt_leg;
    logic         inj_req;
    logic         inj_upper;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    swd_seq #(.W(W), .CONF_N(CONF_N), .WIN_LEN(WIN_LEN), .ACK_TO(ACK_TO)) u_swd_seq (
        .clk (clk), .rst_n (rst_n), .clr (clr), .smp_vld (smp_vld),
        .rad_in (rad_in), .ctr_sect (ctr_sect), .ctr_mag (ctr_mag),
        .rad_nom (rad_nom), .rad_tol (rad_tol), .ctr_thr (ctr_thr),
        .spk_thr (spk_thr), .phase_i (phase_i), .inj_ack (inj_ack),
        .flt (flt), .sw_code (sw_code), .flt_leg (flt_leg),
        .inj_req (inj_req), .inj_upper (inj_upper)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // all tasks start and end just after a falling edge
    task automatic send(input int rad, input int sect, input int mag);
        rad_in   = W'(rad);
        ctr_sect = 3'(sect);
        ctr_mag  = W'(mag);
        smp_vld  = 1'b1;
        @(negedge clk);
        smp_vld  = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic confirm_fault(input int sect, input int mag);
        send(1100, sect, mag);
        send(1100, sect, mag);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset flt", flt, 0);
        chk("R1 reset code", sw_code, 0);
        chk("R1 reset leg", flt_leg, 0);
        chk("R1 reset req", inj_req, 0);
    endtask

    task automatic t_healthy();
        send(1050, 0, 300);
        send(950, 0, 300);
        chk("R2 tolerance edge no flag", flt, 0);
        send(1100, 0, 300);
        chk("R2 single deviant no flag", flt, 0);
        send(1040, 0, 300);
        send(1100, 0, 300);
        chk("R2 run reset by healthy sample", flt, 0);
        send(1100, 0, 300);
        chk("R2 flag on confirming sample", flt, 1);
        chk("R3 sector0 leg A", flt_leg, 1);
        chk("R3 sector0 lower side", inj_upper, 0);
        do_clear();
        chk("R1 clear in request", inj_req + flt, 0);
    endtask

    task automatic t_bad_sector();
        send(1100, 7, 300);
        send(1100, 6, 300);
        chk("R3 invalid sector no flag", flt, 0);
        send(1100, 5, 300);
        chk("R3 sector5 flags", flt, 1);
        chk("R3 sector5 leg B", flt_leg, 2);
        chk("R3 sector5 upper", inj_upper, 1);
        @(negedge clk);
        chk("R5 request after outer fault", inj_req, 1);
        do_clear();
        chk("R1 clear drops request", inj_req, 0);
        chk("R1 clear drops leg", flt_leg, 0);
    endtask

    task automatic t_clamp(input int sect, input int exp_leg, input int exp_code);
        confirm_fault(sect, 40);
        chk("R4 clamp code", sw_code, exp_code);
        chk("R3 clamp leg", flt_leg, exp_leg);
        chk("R4 clamp no request", inj_req, 0);
        repeat (3) @(negedge clk);
        chk("R4 clamp request stays low", inj_req, 0);
        do_clear();
    endtask

    task automatic t_up_spike();
        confirm_fault(3, 300);
        chk("R5 request raised", inj_req, 1);
        chk("R5 upper zero state", inj_upper, 1);
        phase_i = 16'd200;
        inj_ack = 1'b1;
        @(negedge clk);
        inj_ack = 1'b0;
        phase_i = 16'd280;
        @(negedge clk);
        chk("R6 change equal to threshold no spike", sw_code, 0);
        chk("R5 request held in window", inj_req, 1);
        phase_i = 16'd119;
        @(negedge clk);
        chk("R6 negative spike on upper side", sw_code, 1);
        chk("R6 request released", inj_req, 0);
        chk("R3 leg A upper", flt_leg, 1);
        // sticky result
        send(1100, 0, 300);
        send(1100, 0, 300);
        phase_i = 16'd900;
        repeat (2) @(negedge clk);
        chk("R9 code held", sw_code, 1);
        chk("R9 leg held", flt_leg, 1);
        chk("R9 no second request", inj_req, 0);
        do_clear();
    endtask

    task automatic t_up_quiet();
        confirm_fault(1, 300);
        phase_i = 16'd0;
        inj_ack = 1'b1;
        @(negedge clk);
        inj_ack = 1'b0;
        phase_i = 16'd50;
        repeat (WIN_LEN - 1) @(negedge clk);
        chk("R6 window still open", inj_req, 1);
        chk("R6 no code before window end", sw_code, 0);
        @(negedge clk);
        chk("R6 quiet window upper fast", sw_code, 2);
        chk("R3 sector1 leg C", flt_leg, 3);
        do_clear();
    endtask

    task automatic t_lo_spike();
        confirm_fault(2, 300);
        chk("R5 lower zero state", inj_upper, 0);
        phase_i = 16'd200;
        inj_ack = 1'b1;
        @(negedge clk);
        inj_ack = 1'b0;
        phase_i = 16'd120;
        @(negedge clk);
        chk("R7 drop equal to threshold no spike", sw_code, 0);
        phase_i = 16'd119;
        @(negedge clk);
        chk("R7 negative spike lower slow", sw_code, 4);
        chk("R3 sector2 leg B", flt_leg, 2);
        do_clear();
    endtask

    task automatic t_lo_pos();
        confirm_fault(0, 300);
        phase_i = 16'd0;
        inj_ack = 1'b1;
        @(negedge clk);
        inj_ack = 1'b0;
        phase_i = 16'd500;
        repeat (WIN_LEN - 1) @(negedge clk);
        chk("R7 positive change ignored", sw_code, 0);
        @(negedge clk);
        chk("R7 quiet window lower fast", sw_code, 3);
        do_clear();
    endtask

    task automatic t_timeout();
        int seen;
        confirm_fault(4, 300);
        chk("R8 request open", inj_req, 1);
        repeat (ACK_TO - 1) @(negedge clk);
        chk("R8 request before timeout", inj_req, 1);
        chk("R8 no code before timeout", sw_code, 0);
        @(negedge clk);
        chk("R8 request dropped on timeout", inj_req, 0);
        chk("R8 timeout lower fast code", sw_code, 3);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            inj_ack = i[0];
            @(negedge clk);
            if (inj_req) seen++;
        end
        inj_ack = 1'b0;
        chk("R9 one request per diagnosis", seen, 0);
        do_clear();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_healthy();
        t_bad_sector();
        t_clamp(4, 3, 5);
        t_clamp(3, 1, 6);
        t_up_spike();
        t_up_quiet();
        t_lo_spike();
        t_lo_pos();
        t_timeout();
        summary();
        $finish;
    end
endmodule